// File: doc/BRIEF.md
# AES3 biphase-mark frame transmitter

This block turns a stream of stereo audio sample pairs into a serial digital-audio line signal of the AES3 / S/PDIF kind. The transmit clock runs at one tick per half bit cell: 64 ticks per subframe and 128 per frame. Each subframe begins with a sync preamble. The audio word follows, then the validity, user, channel-status and parity bits, and the whole stream is biphase-mark coded. The coded level drives a complementary output pair.

Samples arrive through a one-deep valid/ready holding stage. A pair taken in is sent from the next frame start, and the last pair is sent again if nothing new came in. The host supplies the channel-status bits and the user bits as 192-bit images, one bit per frame of the block. The user bit can also come from an external serial pin instead. A mute control sends zero audio while the framing carries on. A line-disable control and reset both hold the two outputs low. A bidirectional block-start control either reports the first subframe of each channel-status block or, when driven long enough, restarts the frame and block.

Top module: `aes3_bmc_tx`

## Requirements
- R1: A subframe is 32 bit cells. Cells 0 to 3 are the preamble. Cells 4 to 27 carry the 24-bit audio word LSB first, then come validity in cell 28, user in cell 29, channel status in cell 30 and parity in cell 31. The A subframe carries the left sample and the B subframe the right.
- R2: Outside the preamble each bit cell is two clock ticks. The level toggles at every cell start, and toggles again at mid-cell when the bit is 1.
- R3: The preamble spans 8 ticks. Each tick's level is a fixed pattern bit XOR the level just before the subframe. The patterns, first tick first, are 11101000 for the A subframe of frame 0, 11100010 for the other A subframes and 11100100 for B subframes.
- R4: The parity cell makes the count of ones in cells 4 to 31 even.
- R5: Frames are numbered 0 to 191 and wrap. The channel-status cell of frame n carries bit n of `cs_image`.
- R6: When `u_sel_ext` is 0 the user cell of frame n carries bit n of `u_image`. When it is 1 the user cell carries `u_ext` as sampled at the first tick of that subframe.
- R7: With `mute` high at a subframe's first tick, that subframe's audio word is zero. Preambles, V, U, C and parity are still sent.
- R8: While reset is low or `line_off` is high, `txp` and `txn` are both 0. Otherwise `txn` is the complement of `txp`.
- R9: With `blk_dir_in` high, holding `blk_in` high for a 4th consecutive clock restarts transmission at the next tick, at tick 0 of frame 0 of subframe A. This happens once per high pulse, and shorter pulses have no effect.
- R10: With `blk_dir_in` low, `blk_out` is 1 exactly during the A subframe of frame 0. With `blk_dir_in` high it is 0.
- R11: `smp_ready` is 1 exactly when the holding stage is empty. A pair accepted with valid and ready moves to transmission at the next frame start, and the last pair repeats when none is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding stage empty |
| smp_left | input | 24 | Left sample, sent in subframe A |
| smp_right | input | 24 | Right sample, sent in subframe B |
| vbit | input | 1 | Validity bit value |
| u_sel_ext | input | 1 | 1: user bit from `u_ext` |
| u_ext | input | 1 | External user bit |
| u_image | input | BLK | User bits, indexed by frame |
| cs_image | input | BLK | Channel-status bits, indexed by frame |
| mute | input | 1 | Send zero audio |
| line_off | input | 1 | Hold outputs low |
| blk_dir_in | input | 1 | 1: block-start acts as input |
| blk_in | input | 1 | Block-start request |
| blk_out | output | 1 | Block-start indication |
| txp | output | 1 | Line output, true |
| txn | output | 1 | Line output, complement |

## Verification
A behavioural line model rebuilds every subframe from the inputs and is compared with the output pair on every tick. The inputs are varied in several ways. Distinct sample pairs on each frame tell left from right and catch LSB-first ordering. Changing patterns in both bit images separate the frame indexing of C from that of U across a block wrap. A random external user bit shows the per-subframe sampling. Muted and starved stretches separate zeroed audio from repeated audio. Block-start pulses of three and six ticks, placed mid-subframe, separate an ignored request from a forced restart and check the B preamble that follows.

// File: rtl/aes3_bmc_tx.sv
module aes3_bmc_tx #(
  parameter int BLK      = 192,
  parameter int HOLD_CYC = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_valid,
  output logic           smp_ready,
  input  logic [23:0]    smp_left,
  input  logic [23:0]    smp_right,
  input  logic           vbit,
  input  logic           u_sel_ext,
  input  logic           u_ext,
  input  logic [BLK-1:0] u_image,
  input  logic [BLK-1:0] cs_image,
  input  logic           mute,
  input  logic           line_off,
  input  logic           blk_dir_in,
  input  logic           blk_in,
  output logic           blk_out,
  output logic           txp,
  output logic           txn
);
  localparam int FW = $clog2(BLK);
  localparam int CW = $clog2(HOLD_CYC + 2);
  localparam logic [7:0] PAT_B = 8'b11101000;
  localparam logic [7:0] PAT_M = 8'b11100010;
  localparam logic [7:0] PAT_W = 8'b11100100;

  logic [5:0]    hc;
  logic          sub;
  logic [FW-1:0] frm;
  logic [CW-1:0] hi_cnt;
  logic          lvl, pol_q;
  logic [27:0]   word_q;
  logic [23:0]   hold_l, hold_r, cur_l, cur_r;
  logic          hold_full;

  wire force_start = blk_dir_in & blk_in & (hi_cnt == CW'(HOLD_CYC));
  wire sf_start    = (hc == 6'd0);
  wire fr_start    = sf_start & ~sub;
  wire [4:0] slot  = hc[5:1];
  wire [4:0] bidx  = slot - 5'd4;
  wire pol         = sf_start ? lvl : pol_q;
  wire [7:0] pat   = sub ? PAT_W : ((frm == '0) ? PAT_B : PAT_M);

  logic [23:0] aud;
  logic [26:0] body;
  always_comb begin
    aud  = mute ? 24'd0 : (sub ? cur_r : (hold_full ? hold_l : cur_l));
    body = {cs_image[frm], (u_sel_ext ? u_ext : u_image[frm]), vbit, aud};
  end

  logic lvl_nxt;
  always_comb begin
    if (hc < 6'd8)      lvl_nxt = pat[3'd7 - hc[2:0]] ^ pol;
    else if (!hc[0])    lvl_nxt = ~lvl;
    else                lvl_nxt = lvl ^ word_q[bidx];
  end

  assign smp_ready = ~hold_full;
  assign blk_out   = ~blk_dir_in & ~sub & (frm == '0);
  wire   line_en   = rst_n & ~line_off;
  assign txp       = line_en & lvl;
  assign txn       = line_en & ~lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0; sub <= 1'b0; frm <= '0; hi_cnt <= '0;
      lvl <= 1'b0; pol_q <= 1'b0; word_q <= '0;
      hold_l <= '0; hold_r <= '0; cur_l <= '0; cur_r <= '0; hold_full <= 1'b0;
    end else begin
      if (blk_dir_in && blk_in)
        hi_cnt <= (hi_cnt == CW'(HOLD_CYC + 1)) ? hi_cnt : hi_cnt + 1'b1;
      else
        hi_cnt <= '0;

      lvl   <= lvl_nxt;
      pol_q <= pol;
      if (sf_start) word_q <= {^body, body};

      if (fr_start && hold_full) begin
        cur_l <= hold_l; cur_r <= hold_r; hold_full <= 1'b0;
      end else if (smp_valid && !hold_full) begin
        hold_l <= smp_left; hold_r <= smp_right; hold_full <= 1'b1;
      end

      if (force_start) begin
        hc <= '0; sub <= 1'b0; frm <= '0;
      end else begin
        hc <= hc + 1'b1;
        if (hc == 6'd63) begin
          sub <= ~sub;
          if (sub) frm <= (frm == FW'(BLK - 1)) ? '0 : frm + 1'b1;
        end
      end
    end
  end

  p_cell_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hc >= 6'd8 && !hc[0] && !force_start) |=> (lvl != $past(lvl)));

  p_block_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm == FW'(BLK - 1) && sub && hc == 6'd63 && !force_start) |=> (frm == '0 && !sub));

  p_line_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_off |-> (!txp && !txn));

  p_pair_comp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_off |-> (txp != txn));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_start |=> (hc == 6'd0 && !sub && frm == '0));

  p_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
endmodule

// File: tb/aes3_bmc_tx_bench.sv
module aes3_bmc_tx_bench;
  localparam int CLK_NS = 10;
  localparam int BLK = 192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_ready;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic vbit = 1'b0, u_sel_ext = 1'b0, u_ext = 1'b0;
  logic [BLK-1:0] u_image, cs_image;
  logic mute = 1'b0, line_off = 1'b0, blk_dir_in = 1'b0, blk_in = 1'b0;
  logic blk_out, txp, txn;

  aes3_bmc_tx u_aes3_bmc_tx (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right), .vbit(vbit),
    .u_sel_ext(u_sel_ext), .u_ext(u_ext), .u_image(u_image), .cs_image(cs_image),
    .mute(mute), .line_off(line_off), .blk_dir_in(blk_dir_in), .blk_in(blk_in),
    .blk_out(blk_out), .txp(txp), .txn(txn));

  always #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0;
  string phase = "R1";
  bit feed = 1'b0, rnd_u = 1'b0;

  // behavioural line model
  int pos = 0, sb = 0, fr = 0, hcnt = 0, cur_pos = 0, nfeed = 0;
  bit mfull = 0, lastl = 0, took = 0;
  logic [23:0] mhl = 0, mhr = 0, mcl = 0, mcr = 0;
  bit q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = 0; sb = 0; fr = 0; hcnt = 0; mfull = 0; lastl = 0; took = 0;
      mhl = 0; mhr = 0; mcl = 0; mcr = 0; q.delete();
    end else begin
      bit rdy, l;
      bit [27:0] w;
      bit [7:0] pat;
      rdy = !mfull;
      if (pos == 0) begin
        if (sb == 0 && mfull) begin mcl = mhl; mcr = mhr; mfull = 0; end
        w[23:0] = mute ? 24'd0 : (sb != 0 ? mcr : mcl);
        w[24] = vbit;
        w[25] = u_sel_ext ? u_ext : u_image[fr];
        w[26] = cs_image[fr];
        w[27] = ^w[26:0];
        pat = (sb == 0 && fr == 0) ? 8'hE8 : (sb == 0 ? 8'hE2 : 8'hE4);
        q.delete();
        for (int k = 7; k >= 0; k--) q.push_back(pat[k] ^ lastl);
        l = q[7];
        for (int k = 0; k < 28; k++) begin
          l = !l; q.push_back(l);
          l = l ^ w[k]; q.push_back(l);
        end
      end
      cur_pos = pos;
      lastl = q.pop_front();
      if (blk_dir_in && blk_in && hcnt == 3) begin
        pos = 0; sb = 0; fr = 0; q.delete();
      end else begin
        pos++;
        if (pos == 64) begin
          pos = 0; sb ^= 1;
          if (sb == 0) fr = (fr + 1) % BLK;
        end
      end
      hcnt = (blk_dir_in && blk_in) ? (hcnt == 4 ? 4 : hcnt + 1) : 0;
      took = smp_valid && rdy;
      if (took) begin mhl = smp_left; mhr = smp_right; mfull = 1; end
    end
  end

  function automatic string slot_tag(int p);
    int s = p / 2;
    if (s < 4) return "R3";
    if (s == 29) return "R6";
    if (s == 30) return "R5";
    if (s == 31) return "R4";
    return "R1";
  endfunction

  bit prev_en = 0, prev_txp = 0;
  always @(negedge clk) begin
    bit en;
    en = rst_n && !line_off;
    total++;
    if (!en) begin
      if (txp !== 1'b0 || txn !== 1'b0) begin
        bad++; $display("FAIL R8 off txp/txn act=%b%b exp=00", txp, txn);
      end
    end else if (txp !== lastl || txn !== !lastl) begin
      bad++;
      $display("FAIL %s %s tick=%0d frame=%0d sub=%0d act=%b%b exp=%b%b",
               phase, slot_tag(cur_pos), cur_pos, fr, sb, txp, txn, lastl, !lastl);
    end
    if (en && prev_en && cur_pos >= 8 && cur_pos % 2 == 0) begin
      total++;
      if (txp == prev_txp) begin
        bad++; $display("FAIL R2 no cell-start edge act=%b exp=%b", txp, !prev_txp);
      end
    end
    prev_en = en; prev_txp = txp;
    if (rst_n) begin
      total++;
      if (smp_ready !== !mfull) begin
        bad++; $display("FAIL R11 ready act=%b exp=%b", smp_ready, !mfull);
      end
    end
    total++;
    if (blk_out !== (!blk_dir_in && sb == 0 && fr == 0)) begin
      bad++; $display("FAIL R10 blk_out act=%b exp=%b", blk_out, !blk_dir_in && sb == 0 && fr == 0);
    end
  end

  // sample feeder and external user bit
  always @(negedge clk) begin
    smp_valid = feed;
    if (took) begin
      nfeed++;
      smp_left  = 24'(nfeed * 24'h13579B) ^ 24'h800001;
      smp_right = 24'(nfeed * 24'h2468AD) ^ 24'h0F0F01;
    end
    if (rnd_u) u_ext = 1'($urandom);
  end

  task automatic frames(int n);
    repeat (n * 128) @(negedge clk);
  endtask

  task automatic pulse(int len);
    @(negedge clk); blk_in = 1'b1;
    repeat (len) @(negedge clk);
    blk_in = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < BLK; i++) begin
      cs_image[i] = ((i % 7) == 0) || ((i % 5) == 2);
      u_image[i]  = ((i % 3) == 1);
    end
    smp_left = 24'hA5A5A5; smp_right = 24'h5A5A5A;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    feed = 1'b1;
    phase = "R1";  frames(30);
    vbit = 1'b1; u_sel_ext = 1'b1; rnd_u = 1'b1;
    phase = "R6";  frames(30);
    u_sel_ext = 1'b0; rnd_u = 1'b0; vbit = 1'b0;
    phase = "R7";  mute = 1'b1; frames(20); mute = 1'b0;
    phase = "R8";  repeat (300) @(negedge clk); line_off = 1'b1; frames(5); line_off = 1'b0;
    phase = "R11"; feed = 1'b0; frames(10); feed = 1'b1;
    phase = "R5";  frames(110);
    phase = "R9";  blk_dir_in = 1'b1;
    repeat (77) @(negedge clk); pulse(3); frames(2);
    repeat (41) @(negedge clk); pulse(6); frames(3);
    repeat (200) @(negedge clk); pulse(4); frames(2);
    blk_dir_in = 1'b0; frames(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule